// File: doc/BRIEF.md
# Walsh-Code Despreading Decoder

This block sits at the receive side of a shared code-division bus and recovers one data bit per symbol for a single receiver. The bus carries, for every chip position of an 8-chip symbol, a small count: how many active senders drove a 1 on that chip. A receiver does not own a fixed code. At the start of each transfer the channel arbiter hands it a 3-bit code number, and the decoder turns that number into an 8-bit Walsh pattern using a code table it computes itself.

Each chip count is steered by the matching pattern bit into either a positive or a negative running total. When all eight chips of a symbol have been collected, the two totals are compared. Because the codes are orthogonal and balanced, the traffic of other senders adds equally to both totals, and only the receiver's own sender tips the balance. The block can take a whole symbol in one beat (parallel mode), or one chip per beat over eight beats (serial mode).

Chip beats enter through a valid/ready port. A beat moves on a rising clock edge where `in_valid` and `in_ready` are both high. Decoded bits leave through a valid/ready port. A pending result that is not taken holds the output and stalls the input: `in_ready` stays low while `out_valid` is high and `out_ready` is low. A sender may not drop or change a beat while `in_valid` is high and `in_ready` is low.

Top module: `wdec_despread`

## Requirements
- R1: Code number n (0 to 6) selects the pattern whose chip j (j = 0..7) is the parity of ((n+1) AND j). This gives code 0 = 01010101, code 3 = 00001111 and code 6 = 01101001, written chip 0 first. Code number 7 means "no code": every symbol decodes to 0.
- R2: A chip whose pattern bit is 0 adds its count to the positive total. A chip whose pattern bit is 1 adds its count to the negative total. Each running total is 5 bits wide and never exceeds 28.
- R3: The decoded bit is 1 only when the positive total is strictly greater than the negative total. A tie or a smaller positive total gives 0.
- R4: With `par_mode` = 1 latched, one beat carries a whole symbol: chip j occupies `in_chips[3j+2:3j]`. The result is valid on the clock after the beat is accepted, and back-to-back beats give one result per cycle.
- R5: With `par_mode` = 0 latched, a symbol takes eight beats, and chip j comes in `in_chips[2:0]` of the j-th accepted beat. The result becomes valid on the clock after the eighth beat is accepted. No result appears after the first seven beats.
- R6: While `dec_en` is low, and in the first cycle it is high, `in_ready` is low. `code_num` and `par_mode` are captured on the edge where `dec_en` is first seen high. Changes to them while `dec_en` stays high do not affect decoding.
- R7: Dropping `dec_en` discards a partly collected serial symbol and clears both totals. The next symbol starts again at chip 0.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_bit` hold and `in_ready` is low.
- R9: After reset `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_en | input | 1 | Decode enable from interface control |
| code_num | input | 3 | Code number supplied by the arbiter |
| par_mode | input | 1 | 1 = whole symbol per beat, 0 = one chip per beat |
| in_valid | input | 1 | Chip beat offered |
| in_ready | output | 1 | Chip beat accepted this cycle |
| in_chips | input | 24 | Eight 3-bit chip counts (serial mode uses bits 2:0) |
| out_valid | output | 1 | Decoded bit available |
| out_ready | input | 1 | Consumer takes the decoded bit |
| out_bit | output | 1 | Decoded data bit |

## Verification
In parallel mode a decoded bit is due one clock after the edge that accepts its beat. In serial mode it is due one clock after the edge that accepts the eighth chip, and `out_valid` must stay low after the first seven. The bench drives inputs on the falling edge and samples one time unit after the rising edge that should have produced each result, so every check looks at exactly the cycle the requirement names. The effects of enable are checked at the ports: `in_ready` is checked in the cycle enable rises, a code change while enabled must leave the decoded bit as the latched code gives it, and a serial symbol cut short must give way to a correctly decoded fresh symbol.

// File: rtl/wdec_pkg.sv
package wdec_pkg;

  localparam int unsigned CHIPS_DEF  = 8;
  localparam int unsigned CHIP_W_DEF = 3;
  localparam int unsigned ACC_W_DEF  = 5;

  typedef enum logic {
    MODE_SERIAL   = 1'b0,
    MODE_PARALLEL = 1'b1
  } wdec_mode_e;

endpackage

// File: rtl/wdec_code_pool.sv
module wdec_code_pool #(
  parameter int unsigned CHIPS = wdec_pkg::CHIPS_DEF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [$clog2(CHIPS)-1:0]   code_num,
  input  logic                       par_sel,
  input  logic                       beat,
  output logic                       armed,
  output logic                       par_q,
  output logic                       code_ok,
  output logic [$clog2(CHIPS)-1:0]   code_q,
  output logic [CHIPS-1:0]           code_vec,
  output logic                       cur_bit,
  output logic                       judge
);
  import wdec_pkg::*;

  localparam int unsigned CODE_W = $clog2(CHIPS);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(CHIPS - 1);

  logic              en_q;
  wdec_mode_e        mode_q;
  logic [CODE_W-1:0] idx_q;
  logic [CODE_W-1:0] row_sel;

  // capture code number and mode on the first enabled cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= '0;
      mode_q <= MODE_SERIAL;
    end else begin
      en_q <= en;
      if (en && !en_q) begin
        code_q <= code_num;
        mode_q <= par_sel ? MODE_PARALLEL : MODE_SERIAL;
      end
    end
  end

  // chip position inside a serial symbol
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (!en) begin
      idx_q <= '0;
    end else if (beat && mode_q == MODE_SERIAL) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + CODE_W'(1);
    end
  end

  // Walsh row (n+1): chip j is the parity of row AND j
  assign row_sel = code_q + CODE_W'(1);

  for (genvar j = 0; j < CHIPS; j++) begin : g_chip
    assign code_vec[j] = ^(row_sel & CODE_W'(j));
  end

  assign par_q   = (mode_q == MODE_PARALLEL);
  assign code_ok = (code_q != LAST);
  assign armed   = en & en_q;
  assign cur_bit = code_vec[idx_q];
  assign judge   = par_q | (idx_q == LAST);

endmodule

// File: rtl/wdec_accum.sv
module wdec_accum #(
  parameter int unsigned CHIPS  = wdec_pkg::CHIPS_DEF,
  parameter int unsigned CHIP_W = wdec_pkg::CHIP_W_DEF,
  parameter int unsigned ACC_W  = wdec_pkg::ACC_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    beat,
  input  logic                    par_q,
  input  logic                    judge,
  input  logic                    code_ok,
  input  logic [CHIPS-1:0]        code_vec,
  input  logic                    cur_bit,
  input  logic [CHIPS*CHIP_W-1:0] chips,
  output logic [ACC_W-1:0]        pos_tot,
  output logic [ACC_W-1:0]        neg_tot,
  output logic [ACC_W-1:0]        pos_acc,
  output logic [ACC_W-1:0]        neg_acc
);

  logic [CHIP_W-1:0] lane [CHIPS];
  logic [ACC_W-1:0]  par_pos, par_neg;
  logic [ACC_W-1:0]  ser_pos, ser_neg;

  // an unassigned code contributes nothing to either side
  for (genvar j = 0; j < CHIPS; j++) begin : g_lane
    assign lane[j] = code_ok ? chips[j*CHIP_W +: CHIP_W] : '0;
  end

  // whole-symbol classification in one pass
  always_comb begin
    par_pos = '0;
    par_neg = '0;
    for (int j = 0; j < CHIPS; j++) begin
      if (code_vec[j]) par_neg = par_neg + ACC_W'(lane[j]);
      else             par_pos = par_pos + ACC_W'(lane[j]);
    end
  end

  // one chip per beat, arriving on lane 0
  always_comb begin
    ser_pos = pos_acc;
    ser_neg = neg_acc;
    if (cur_bit) ser_neg = neg_acc + ACC_W'(lane[0]);
    else         ser_pos = pos_acc + ACC_W'(lane[0]);
  end

  assign pos_tot = par_q ? par_pos : ser_pos;
  assign neg_tot = par_q ? par_neg : ser_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_acc <= '0;
      neg_acc <= '0;
    end else if (!en) begin
      pos_acc <= '0;
      neg_acc <= '0;
    end else if (beat && !par_q) begin
      if (judge) begin
        pos_acc <= '0;
        neg_acc <= '0;
      end else begin
        pos_acc <= ser_pos;
        neg_acc <= ser_neg;
      end
    end
  end

endmodule

// File: rtl/wdec_decide.sv
module wdec_decide #(
  parameter int unsigned ACC_W = wdec_pkg::ACC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             code_ok,
  input  logic [ACC_W-1:0] pos_tot,
  input  logic [ACC_W-1:0] neg_tot,
  input  logic             out_ready,
  output logic             out_valid,
  output logic             out_bit,
  output logic             space
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_bit   <= code_ok && (pos_tot > neg_tot);
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign space = !out_valid || out_ready;

endmodule

// File: rtl/wdec_despread.sv
module wdec_despread #(
  parameter int unsigned CHIPS  = wdec_pkg::CHIPS_DEF,
  parameter int unsigned CHIP_W = wdec_pkg::CHIP_W_DEF,
  parameter int unsigned ACC_W  = wdec_pkg::ACC_W_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      dec_en,
  input  logic [$clog2(CHIPS)-1:0]  code_num,
  input  logic                      par_mode,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [CHIPS*CHIP_W-1:0]   in_chips,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic                      out_bit
);

  localparam int unsigned CODE_W = $clog2(CHIPS);

  logic              armed, par_q, code_ok, cur_bit, judge;
  logic              beat, space;
  logic [CODE_W-1:0] code_q;
  logic [CHIPS-1:0]  code_vec;
  logic [ACC_W-1:0]  pos_tot, neg_tot, pos_acc, neg_acc;

  assign in_ready = armed && space;
  assign beat     = in_valid && in_ready;

  wdec_code_pool #(.CHIPS(CHIPS)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (dec_en),
    .code_num (code_num),
    .par_sel  (par_mode),
    .beat     (beat),
    .armed    (armed),
    .par_q    (par_q),
    .code_ok  (code_ok),
    .code_q   (code_q),
    .code_vec (code_vec),
    .cur_bit  (cur_bit),
    .judge    (judge)
  );

  wdec_accum #(.CHIPS(CHIPS), .CHIP_W(CHIP_W), .ACC_W(ACC_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (dec_en),
    .beat     (beat),
    .par_q    (par_q),
    .judge    (judge),
    .code_ok  (code_ok),
    .code_vec (code_vec),
    .cur_bit  (cur_bit),
    .chips    (in_chips),
    .pos_tot  (pos_tot),
    .neg_tot  (neg_tot),
    .pos_acc  (pos_acc),
    .neg_acc  (neg_acc)
  );

  wdec_decide #(.ACC_W(ACC_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (beat && judge),
    .code_ok   (code_ok),
    .pos_tot   (pos_tot),
    .neg_tot   (neg_tot),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .space     (space)
  );

endmodule

// File: rtl/wdec_despread_chk.sv
module wdec_despread_chk #(
  parameter int unsigned CHIPS  = wdec_pkg::CHIPS_DEF,
  parameter int unsigned CHIP_W = wdec_pkg::CHIP_W_DEF,
  parameter int unsigned ACC_W  = wdec_pkg::ACC_W_DEF
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     dec_en,
  input logic                     in_ready,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic                     out_bit,
  input logic                     beat,
  input logic                     judge,
  input logic                     par_q,
  input logic [$clog2(CHIPS)-1:0] code_q,
  input logic [ACC_W-1:0]         pos_acc,
  input logic [ACC_W-1:0]         neg_acc
);

  localparam int unsigned ACC_MAX = (CHIPS / 2) * ((1 << CHIP_W) - 1);

  // R6
  en_low_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |-> !in_ready);

  // R6
  en_rise_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec_en) |-> !in_ready);

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dec_en) && dec_en && in_ready) |=> $stable(code_q) || !dec_en);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R8
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R4
  par_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && par_q) |=> out_valid);

  // R5
  result_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(beat && judge));

  // R2
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_acc <= ACC_W'(ACC_MAX)) && (neg_acc <= ACC_W'(ACC_MAX)));

  // R7
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_en |=> (pos_acc == '0 && neg_acc == '0));

endmodule

bind wdec_despread wdec_despread_chk #(
  .CHIPS(CHIPS), .CHIP_W(CHIP_W), .ACC_W(ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_en    (dec_en),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .beat      (beat),
  .judge     (judge),
  .par_q     (par_q),
  .code_q    (code_q),
  .pos_acc   (pos_acc),
  .neg_acc   (neg_acc)
);

// File: tb/wdec_despread_test.sv
module wdec_despread_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_en = 1'b0;
  logic [2:0]  code_num = '0;
  logic        par_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_chips = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_bit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdec_despread uut (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .code_num(code_num),
    .par_mode(par_mode), .in_valid(in_valid), .in_ready(in_ready),
    .in_chips(in_chips), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit)
  );

  // code table written chip 0 first (leftmost)
  function automatic logic [7:0] tb_code(input int n);
    case (n)
      0: return 8'b01010101;
      1: return 8'b00110011;
      2: return 8'b01100110;
      3: return 8'b00001111;
      4: return 8'b01011010;
      5: return 8'b00111100;
      6: return 8'b01101001;
      default: return 8'b00000000;
    endcase
  endfunction

  function automatic logic tb_cbit(input int n, input int j);
    logic [7:0] c;
    c = tb_code(n);
    return c[7-j];
  endfunction

  // bus chip counts for a set of active senders
  function automatic logic [23:0] tb_encode(input logic [6:0] act, input logic [6:0] dat);
    logic [23:0] v;
    v = '0;
    for (int j = 0; j < 8; j++) begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < 7; k++)
        if (act[k] && (dat[k] ^ tb_cbit(k, j))) cnt++;
      v[3*j +: 3] = 3'(cnt);
    end
    return v;
  endfunction

  function automatic logic tb_expect(input int n, input logic [23:0] lanes);
    int p, m;
    if (n == 7) return 1'b0;
    p = 0; m = 0;
    for (int j = 0; j < 8; j++) begin
      if (tb_cbit(n, j)) m += int'(lanes[3*j +: 3]);
      else               p += int'(lanes[3*j +: 3]);
    end
    return p > m;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic arm(input int code, input logic par);
    @(negedge clk);
    dec_en = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    dec_en = 1'b1; code_num = 3'(code); par_mode = par;
    #1 chk(in_ready == 1'b0, "R6 ready in rise cycle", int'(in_ready), 0);
  endtask

  task automatic par_sym(input logic [23:0] lanes, input logic exp, input string req);
    @(negedge clk);
    in_valid = 1'b1; in_chips = lanes;
    @(posedge clk);
    #1;
    chk(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
    chk(out_bit == exp, {req, " bit"}, int'(out_bit), int'(exp));
  endtask

  task automatic ser_sym(input logic [23:0] lanes, input logic exp, input string req);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_chips = {21'b0, lanes[3*j +: 3]};
      @(posedge clk);
      #1;
      if (j == 3) chk(out_valid == 1'b0, {req, " early valid"}, int'(out_valid), 0);
      if (j == 7) begin
        chk(out_valid == 1'b1, {req, " valid"}, int'(out_valid), 1);
        chk(out_bit == exp, {req, " bit"}, int'(out_bit), int'(exp));
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    logic [6:0]  act, dat;
    logic [23:0] lanes;
    logic        e;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R9
    chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
    chk(in_ready == 1'b0, "R9 in_ready in reset", int'(in_ready), 0);
    @(negedge clk) rst_n = 1'b1;
    #1 chk(in_ready == 1'b0, "R6 ready while disabled", int'(in_ready), 0);

    // R4 R1 R2 R3: parallel decode of every code among random others
    for (int c = 0; c < 7; c++) begin
      arm(c, 1'b1);
      for (int n = 0; n < 16; n++) begin
        act = 7'($urandom); dat = 7'($urandom);
        lanes = tb_encode(act, dat);
        e = tb_expect(c, lanes);
        if (act[c]) chk(e == dat[c], "R1 model self-check", int'(e), int'(dat[c]));
        par_sym(lanes, e, "R4 parallel");
      end
      idle();
    end

    // R3: silent bus ties, decodes 0
    arm(0, 1'b1);
    par_sym(24'd0, 1'b0, "R3 tie");
    // R3: all seven senders send 1, target still 1
    par_sym(tb_encode(7'h7f, 7'h7f), 1'b1, "R3 full load");
    idle();

    // R1: code number 7 never decodes 1
    arm(7, 1'b1);
    par_sym({8{3'd1}}, 1'b0, "R1 no-code");
    idle();

    // R6: code change while enabled is ignored
    arm(1, 1'b1);
    @(negedge clk) code_num = 3'd4;
    par_sym(tb_encode(7'b0000010, 7'b0000010), 1'b1, "R6 latched code");
    idle();

    // R5: serial decode of every code
    for (int c = 0; c < 7; c++) begin
      arm(c, 1'b0);
      for (int n = 0; n < 3; n++) begin
        act = 7'($urandom); dat = 7'($urandom);
        act[c] = 1'b1;
        lanes = tb_encode(act, dat);
        ser_sym(lanes, dat[c], "R5 serial");
      end
      idle();
    end

    // R7: partial serial symbol discarded by enable drop
    arm(2, 1'b0);
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      in_valid = 1'b1; in_chips = 24'd7;
    end
    arm(2, 1'b0);
    ser_sym(tb_encode(7'b0101101, 7'b0000000), 1'b0, "R7 restart");
    ser_sym(tb_encode(7'b0000100, 7'b0000100), 1'b1, "R7 next");
    idle();

    // R8: back-pressure holds output and stalls input
    arm(3, 1'b1);
    @(negedge clk) out_ready = 1'b0;
    par_sym(tb_encode(7'b0001000, 7'b0001000), 1'b1, "R8 first");
    @(negedge clk);
    in_valid = 1'b1; in_chips = tb_encode(7'b0001000, 7'b0000000);
    #1 chk(in_ready == 1'b0, "R8 stall", int'(in_ready), 0);
    @(posedge clk); #1;
    chk(out_valid == 1'b1, "R8 hold valid", int'(out_valid), 1);
    chk(out_bit == 1'b1, "R8 hold bit", int'(out_bit), 1);
    @(negedge clk) out_ready = 1'b1;
    @(posedge clk); #1;
    chk(out_bit == 1'b0, "R8 after release", int'(out_bit), 0);
    idle();

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule